// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block walks an SDRAM device through its mode-register bring-up after reset. Software or a reset controller pulses `start_i` once. The block then emits a fixed series of single-cycle command strobes on a one-hot word. Each strobe is followed by an idle gap whose length is programmable but never below a floor. When the series is finished, `done_o` rises and stays high until the next reset.

A strap input chooses between a first-generation and a second-generation DDR device. It is sampled only in the cycle that accepts `start_i`. The two generations differ in their command order. The second-generation order also issues the two extended-register selects, and it ends with an off-chip-driver calibration enter and exit pair on the extended mode register.

For each mode-register or extended-mode-register strobe, the register value is placed on `val_o` in the same cycle. At completion, the block also presents a refresh-control word and an initial DQS delay tap for every byte lane. The downstream refresh engine and the read-capture logic take these words from the block.

Top module: `sdram_init_seq`

## Requirements
- R1: `cmd_o` carries at most one set bit in any cycle. Every strobe lasts exactly one cycle. Bit meanings: bit0 mode-register load, bit1 extended-mode load, bit2 auto-refresh, bit3 precharge, bit4 extended register 2 select, bit5 extended register 3 select.
- R2: With `strap_ddr1_i`=1, the strobes come in this order (with `val_o` shown in parentheses): precharge; extended-mode (0x000); mode (0x133); precharge; auto-refresh; auto-refresh; mode (0x033).
- R3: With `strap_ddr1_i`=0, the strobes come in this order: precharge; ext-reg-2; ext-reg-3; extended-mode (0x402); mode (0x143); precharge; auto-refresh; auto-refresh; mode (0x043); extended-mode (0x782); extended-mode (0x402).
- R4: `val_o` is zero in every cycle that has neither a mode nor an extended-mode strobe.
- R5: The first strobe appears in the cycle after the clock edge that accepts `start_i`. Exactly G idle cycles separate consecutive strobes. G is `gap_cfg_i` sampled at start, raised to MIN_GAP (16) when below it.
- R6: The strap and `gap_cfg_i` are sampled only when start is accepted. Later changes to either have no effect on the run.
- R7: A `start_i` pulse received while a run is in progress, or after `done_o` has risen, has no effect. `done_o` stays high until reset.
- R8: `done_o` rises G+1 cycles after the last strobe. No strobe appears while `done_o` is high.
- R9: `refresh_o` is zero before done. From the done cycle on, it equals 0x4138: enable bit 14 set and period field [9:0] = 312.
- R10: Each TAP_W-bit lane of `tap_o` is zero before done. From the done cycle on, each lane is 0x20 for the first-generation strap and 0x10 for the second-generation strap.
- R11: After reset, and until start is accepted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches the sequence from idle |
| strap_ddr1_i | input | 1 | 1 = first-generation order, 0 = second-generation order |
| gap_cfg_i | input | GAP_W | Requested idle cycles between strobes |
| cmd_o | output | 6 | One-hot command strobe |
| val_o | output | VAL_W | Register value that goes with a mode or extended-mode strobe |
| done_o | output | 1 | Sequence complete, sticky |
| refresh_o | output | REF_W | Refresh-control word |
| tap_o | output | LANES*TAP_W | Initial DQS tap, one field per byte lane |

## Verification
The bench runs both strap settings. The gap request is set below the floor, exactly at the floor, just above it, and at the maximum. These cases separate a clamped gap from a passed-through gap, and they catch off-by-one spacing at each edge of the clamp. In one run, the strap and the gap request are flipped mid-sequence and a stray start is injected; the output must still follow the originally sampled order. A further start after completion shows that the done state cannot be left.

// File: rtl/sdram_init_pkg.sv
`timescale 1ns/1ps
package sdram_init_pkg;

   localparam int CMD_W    = 6;
   localparam int CMD_MRS  = 0;
   localparam int CMD_EMRS = 1;
   localparam int CMD_AREF = 2;
   localparam int CMD_PRE  = 3;
   localparam int CMD_EMR2 = 4;
   localparam int CMD_EMR3 = 5;

   localparam int MR_W       = 12;
   localparam int STEPS_GEN1 = 7;
   localparam int STEPS_GEN2 = 11;
   localparam int STEPS_MAX  = (STEPS_GEN1 > STEPS_GEN2) ? STEPS_GEN1 : STEPS_GEN2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/sdram_init_steps.sv
`timescale 1ns/1ps
module sdram_init_steps
   import sdram_init_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             gen1_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [CMD_W-1:0] strobe_o,
   output logic [MR_W-1:0]  val_o,
   output logic [IDX_W-1:0] count_o
);

   if ((1 << IDX_W) <= STEPS_MAX) begin : g_idx_too_narrow
      $fatal(1, "IDX_W cannot hold the step count");
   end

   assign count_o = gen1_i ? IDX_W'(STEPS_GEN1) : IDX_W'(STEPS_GEN2);

   always_comb begin
      strobe_o = '0;
      val_o    = '0;
      if (gen1_i) begin
         case (int'(idx_i))
            0: strobe_o[CMD_PRE] = 1'b1;
            1: begin strobe_o[CMD_EMRS] = 1'b1; val_o = MR_W'('h000); end
            2: begin strobe_o[CMD_MRS]  = 1'b1; val_o = MR_W'('h133); end
            3: strobe_o[CMD_PRE]  = 1'b1;
            4: strobe_o[CMD_AREF] = 1'b1;
            5: strobe_o[CMD_AREF] = 1'b1;
            6: begin strobe_o[CMD_MRS]  = 1'b1; val_o = MR_W'('h033); end
            default: strobe_o = '0;
         endcase
      end else begin
         case (int'(idx_i))
            0:  strobe_o[CMD_PRE]  = 1'b1;
            1:  strobe_o[CMD_EMR2] = 1'b1;
            2:  strobe_o[CMD_EMR3] = 1'b1;
            3:  begin strobe_o[CMD_EMRS] = 1'b1; val_o = MR_W'('h402); end
            4:  begin strobe_o[CMD_MRS]  = 1'b1; val_o = MR_W'('h143); end
            5:  strobe_o[CMD_PRE]  = 1'b1;
            6:  strobe_o[CMD_AREF] = 1'b1;
            7:  strobe_o[CMD_AREF] = 1'b1;
            8:  begin strobe_o[CMD_MRS]  = 1'b1; val_o = MR_W'('h043); end
            9:  begin strobe_o[CMD_EMRS] = 1'b1; val_o = MR_W'('h782); end
            10: begin strobe_o[CMD_EMRS] = 1'b1; val_o = MR_W'('h402); end
            default: strobe_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/sdram_init_gap.sv
`timescale 1ns/1ps
module sdram_init_gap #(
   parameter int GAP_W   = 8,
   parameter int MIN_GAP = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture_i,
   input  logic [GAP_W-1:0] cfg_i,
   input  logic             arm_i,
   output logic             expired_o
);

   localparam logic [GAP_W-1:0] FLOOR = GAP_W'(MIN_GAP);

   if (MIN_GAP < 1 || MIN_GAP >= (1 << GAP_W)) begin : g_bad_floor
      $fatal(1, "MIN_GAP must lie in 1 .. 2**GAP_W-1");
   end

   logic [GAP_W-1:0] gap_q;
   logic [GAP_W-1:0] cnt_q;
   logic [GAP_W-1:0] eff;

   assign eff = capture_i ? ((cfg_i < FLOOR) ? FLOOR : cfg_i) : gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q <= FLOOR;
         cnt_q <= '0;
      end else begin
         if (capture_i) gap_q <= eff;
         if (arm_i)             cnt_q <= eff;
         else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= gap_q);
   p_arm_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> cnt_q >= FLOOR);
   p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/sdram_init_words.sv
`timescale 1ns/1ps
module sdram_init_words #(
   parameter int REF_W        = 16,
   parameter int REF_PERIOD   = 312,
   parameter int REF_PERIOD_W = 10,
   parameter int REF_EN_BIT   = 14,
   parameter int TAP_W        = 7,
   parameter int LANES        = 2,
   parameter int GEN1_TAP     = 'h20,
   parameter int GEN2_TAP     = 'h10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fire_i,
   input  logic                   gen1_i,
   output logic [REF_W-1:0]       refresh_o,
   output logic [LANES*TAP_W-1:0] tap_o
);

   localparam logic [REF_W-1:0] REF_WORD = REF_W'((1 << REF_EN_BIT) | REF_PERIOD);
   localparam logic [TAP_W-1:0] TAP_G1   = TAP_W'(GEN1_TAP);
   localparam logic [TAP_W-1:0] TAP_G2   = TAP_W'(GEN2_TAP);

   if (REF_PERIOD >= (1 << REF_PERIOD_W)) begin : g_bad_period
      $fatal(1, "REF_PERIOD does not fit its field");
   end
   if (REF_EN_BIT >= REF_W || REF_EN_BIT < REF_PERIOD_W) begin : g_bad_enable
      $fatal(1, "REF_EN_BIT must sit above the period field inside REF_W");
   end
   if (GEN1_TAP >= (1 << TAP_W) || GEN2_TAP >= (1 << TAP_W)) begin : g_bad_tap
      $fatal(1, "tap values do not fit TAP_W");
   end
   if (LANES < 1) begin : g_bad_lanes
      $fatal(1, "LANES must be at least 1");
   end

   logic [REF_W-1:0] refresh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      refresh_q <= '0;
      else if (fire_i) refresh_q <= REF_WORD;
   end
   assign refresh_o = refresh_q;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [TAP_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      lane_q <= '0;
         else if (fire_i) lane_q <= gen1_i ? TAP_G1 : TAP_G2;
      end
      assign tap_o[ln*TAP_W +: TAP_W] = lane_q;

      p_lane_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (lane_q != '0 && !fire_i) |=> $stable(lane_q));
   end

   p_ref_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_q != '0 && !fire_i) |=> $stable(refresh_q));
   p_ref_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> refresh_q == REF_WORD);

endmodule

// File: rtl/sdram_init_seq.sv
`timescale 1ns/1ps
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int VAL_W        = 13,
   parameter int GAP_W        = 8,
   parameter int MIN_GAP      = 16,
   parameter int REF_W        = 16,
   parameter int REF_PERIOD   = 312,
   parameter int REF_PERIOD_W = 10,
   parameter int REF_EN_BIT   = 14,
   parameter int TAP_W        = 7,
   parameter int LANES        = 2,
   parameter int GEN1_TAP     = 'h20,
   parameter int GEN2_TAP     = 'h10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic                   strap_ddr1_i,
   input  logic [GAP_W-1:0]       gap_cfg_i,
   output logic [5:0]             cmd_o,
   output logic [VAL_W-1:0]       val_o,
   output logic                   done_o,
   output logic [REF_W-1:0]       refresh_o,
   output logic [LANES*TAP_W-1:0] tap_o
);

   localparam int IDX_W = $clog2(STEPS_MAX + 1);

   if (VAL_W < MR_W) begin : g_val_narrow
      $fatal(1, "VAL_W must hold a mode-register value");
   end

   seq_state_e       st_q;
   logic [IDX_W-1:0] idx_q;
   logic             gen1_q;
   logic [CMD_W-1:0] cmd_q;
   logic [VAL_W-1:0] val_q;
   logic             done_q;

   logic             launch;
   logic             sel_gen1;
   logic [IDX_W-1:0] sel_idx;
   logic [CMD_W-1:0] rom_strobe;
   logic [MR_W-1:0]  rom_val;
   logic [IDX_W-1:0] rom_count;
   logic             expired;
   logic             step;
   logic             finish;

   assign launch   = (st_q == ST_IDLE) && start_i;
   assign sel_gen1 = (st_q == ST_IDLE) ? strap_ddr1_i : gen1_q;
   assign sel_idx  = (st_q == ST_IDLE) ? '0 : idx_q;
   assign step     = launch || ((st_q == ST_RUN) && expired && (idx_q != rom_count));
   assign finish   = (st_q == ST_RUN) && expired && (idx_q == rom_count);

   sdram_init_steps #(.IDX_W(IDX_W)) u_steps (
      .gen1_i   (sel_gen1),
      .idx_i    (sel_idx),
      .strobe_o (rom_strobe),
      .val_o    (rom_val),
      .count_o  (rom_count)
   );

   sdram_init_gap #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) u_gap (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (launch),
      .cfg_i     (gap_cfg_i),
      .arm_i     (step),
      .expired_o (expired)
   );

   sdram_init_words #(
      .REF_W        (REF_W),
      .REF_PERIOD   (REF_PERIOD),
      .REF_PERIOD_W (REF_PERIOD_W),
      .REF_EN_BIT   (REF_EN_BIT),
      .TAP_W        (TAP_W),
      .LANES        (LANES),
      .GEN1_TAP     (GEN1_TAP),
      .GEN2_TAP     (GEN2_TAP)
   ) u_words (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_i    (finish),
      .gen1_i    (gen1_q),
      .refresh_o (refresh_o),
      .tap_o     (tap_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         gen1_q <= 1'b0;
         cmd_q  <= '0;
         val_q  <= '0;
         done_q <= 1'b0;
      end else begin
         cmd_q <= step ? rom_strobe : '0;
         val_q <= step ? VAL_W'(rom_val) : '0;
         if (launch) begin
            gen1_q <= strap_ddr1_i;
            st_q   <= ST_RUN;
         end
         if (step) idx_q <= sel_idx + IDX_W'(1);
         if (finish) begin
            st_q   <= ST_FIN;
            done_q <= 1'b1;
         end
      end
   end

   assign cmd_o  = cmd_q;
   assign val_o  = val_q;
   assign done_o = done_q;

   // spacing monitor for the gap floor
   logic [GAP_W:0] quiet_q;
   logic           seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_q <= '0;
         seen_q  <= 1'b0;
      end else if (cmd_q != '0) begin
         quiet_q <= '0;
         seen_q  <= 1'b1;
      end else if (quiet_q != '1) begin
         quiet_q <= quiet_q + 1'b1;
      end
   end

   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_o));
   p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o != '0) |=> (cmd_o == '0));
   p_val_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_o[CMD_MRS] || cmd_o[CMD_EMRS]) |-> (val_o == '0));
   p_gap_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_o != '0) && seen_q) |-> (quiet_q >= (GAP_W+1)'(MIN_GAP)));
   p_strap_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> $stable(gen1_q));
   p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o);
   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cmd_o == '0));
   p_words_before_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (refresh_o == '0 && tap_o == '0));

endmodule

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;

   localparam int VAL_W   = 13;
   localparam int GAP_W   = 8;
   localparam int MIN_GAP = 16;
   localparam int REF_W   = 16;
   localparam int TAP_W   = 7;
   localparam int LANES   = 2;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   start = 1'b0;
   logic                   strap = 1'b0;
   logic [GAP_W-1:0]       gap_cfg = '0;
   logic [5:0]             cmd;
   logic [VAL_W-1:0]       val;
   logic                   done;
   logic [REF_W-1:0]       refresh;
   logic [LANES*TAP_W-1:0] tap;

   always #5 clk = ~clk;

   sdram_init_seq u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .strap_ddr1_i (strap),
      .gap_cfg_i    (gap_cfg),
      .cmd_o        (cmd),
      .val_o        (val),
      .done_o       (done),
      .refresh_o    (refresh),
      .tap_o        (tap)
   );

   int    checks   = 0;
   int    fails    = 0;
   bit    checking = 1'b0;
   bit    finished = 1'b0;
   string phase    = "R11";

   // expected command lists (strobe bit, value)
   function automatic logic [5:0] exp_cmd(int g1, int k);
      int b;
      if (g1 != 0) begin
         case (k)
            0: b = 3; 1: b = 1; 2: b = 0; 3: b = 3;
            4: b = 2; 5: b = 2; default: b = 0;
         endcase
      end else begin
         case (k)
            0: b = 3; 1: b = 4; 2: b = 5; 3: b = 1; 4: b = 0;
            5: b = 3; 6: b = 2; 7: b = 2; 8: b = 0; default: b = 1;
         endcase
      end
      return 6'(1 << b);
   endfunction

   function automatic int exp_val(int g1, int k);
      if (g1 != 0) begin
         case (k)
            2: return 'h133;
            6: return 'h033;
            default: return 0;
         endcase
      end
      case (k)
         3: return 'h402; 4: return 'h143; 8: return 'h043;
         9: return 'h782; 10: return 'h402;
         default: return 0;
      endcase
   endfunction

   // behavioural model state, advanced at each rising edge
   int m_busy = 0;
   int m_t    = 0;
   int m_gen1 = 0;
   int m_gap  = MIN_GAP;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy <= 0;
         m_t    <= 0;
      end else if (m_busy == 0) begin
         if (start) begin
            m_busy <= 1;
            m_t    <= 1;
            m_gen1 <= int'(strap);
            m_gap  <= (int'(gap_cfg) < MIN_GAP) ? MIN_GAP : int'(gap_cfg);
         end
      end else begin
         m_t <= m_t + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s [%s] %s: actual %0h expected %0h at %0t",
                  req, phase, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (checking) begin
         logic [5:0]             e_cmd;
         int                     e_val;
         bit                     e_done;
         logic [LANES*TAP_W-1:0] e_tap;
         int                     per;
         int                     n;
         e_cmd  = '0;
         e_val  = 0;
         e_done = 1'b0;
         e_tap  = '0;
         if (m_busy != 0) begin
            per = m_gap + 1;
            n   = (m_gen1 != 0) ? 7 : 11;
            if (((m_t - 1) % per) == 0 && ((m_t - 1) / per) < n) begin
               e_cmd = exp_cmd(m_gen1, (m_t - 1) / per);
               e_val = exp_val(m_gen1, (m_t - 1) / per);
            end
            if (m_t >= 1 + n * per) begin
               e_done = 1'b1;
               for (int ln = 0; ln < LANES; ln++)
                  e_tap[ln*TAP_W +: TAP_W] = (m_gen1 != 0) ? TAP_W'('h20) : TAP_W'('h10);
            end
         end
         chk($onehot0(cmd), "R1", "one-hot strobe", cmd, 0);
         if (m_busy == 0)
            chk(cmd == 0 && val == 0 && !done, "R11", "idle outputs", {cmd, val, done}, 0);
         else if (m_gen1 != 0)
            chk(cmd == e_cmd, "R2 R5", "strobe", cmd, e_cmd);
         else
            chk(cmd == e_cmd, "R3 R5", "strobe", cmd, e_cmd);
         chk(int'(val) == e_val, "R4", "value bus", val, e_val);
         chk(done == e_done, "R8", "done", done, e_done);
         chk(refresh == (e_done ? 16'h4138 : 16'h0), "R9", "refresh word",
             refresh, e_done ? 16'h4138 : 16'h0);
         chk(tap == e_tap, "R10", "tap lanes", tap, e_tap);
      end
   end

   task automatic do_reset();
      checking = 1'b0;
      start    = 1'b0;
      rst_n    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n    = 1'b1;
      checking = 1'b1;
   endtask

   task automatic launch(input logic g1, input int cfg);
      @(negedge clk);
      strap   = g1;
      gap_cfg = GAP_W'(cfg);
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
   endtask

   function automatic int run_len(input logic g1, input int cfg);
      int g;
      g = (cfg < MIN_GAP) ? MIN_GAP : cfg;
      return (g1 ? 7 : 11) * (g + 1) + 24;
   endfunction

   initial begin
      // R11: reset and idle before any start
      phase = "R11";
      do_reset();
      repeat (12) @(negedge clk);

      // R2 R5: first-generation order, request below floor
      phase = "R2 R5 gap0";
      launch(1'b1, 0);
      repeat (run_len(1'b1, 0)) @(negedge clk);

      // R7: start after done has no effect
      phase = "R7 restart";
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (60) @(negedge clk);

      // R3 R5: second-generation order, gap above floor
      phase = "R3 R5 gap20";
      do_reset();
      launch(1'b0, 20);
      repeat (run_len(1'b0, 20)) @(negedge clk);

      // R6 R7: disturb strap, gap and start mid-run
      phase = "R6 R7 disturb";
      do_reset();
      launch(1'b0, 16);
      repeat (30) @(negedge clk);
      strap   = 1'b1;
      gap_cfg = 8'd200;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      repeat (run_len(1'b0, 16)) @(negedge clk);

      // R5 boundary: one below floor and one above
      phase = "R5 gap15";
      do_reset();
      launch(1'b1, 15);
      repeat (run_len(1'b1, 15)) @(negedge clk);

      phase = "R5 gap17";
      do_reset();
      launch(1'b1, 17);
      repeat (run_len(1'b1, 17)) @(negedge clk);

      // R5: widest gap
      phase = "R3 R5 gap255";
      do_reset();
      launch(1'b0, 255);
      repeat (run_len(1'b0, 255)) @(negedge clk);

      checking = 1'b0;
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog [%s]: actual running expected finished", phase);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule